// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Status

This block turns a bit-serial HDLC line into a byte stream for a receive FIFO. Bits arrive LSB first on `bit_in`, qualified by `bit_vld`. The deframer finds flag sequences and removes the zeros inserted by the transmitter's stuffing. It packs the remaining bits into bytes and runs the CRC-16 frame check over them. Every byte of frame content, including the two check bytes, is offered on a plain write port made of `byte_out` and `byte_vld`.

At the end of each frame one extra byte follows the frame data. That byte carries the frame's status and is marked by `eof`. The status byte is 0x00 for a frame whose check sequence is correct, 0x01 for a check error, 0x02 for a frame that is too short or not a whole number of bytes, and 0xFF for a frame that was aborted. A consumer reading the FIFO therefore gets the whole frame followed by its verdict. Address and control parsing, and the FIFO itself, sit outside this block.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Flags (bit pattern 0,1,1,1,1,1,1,0 on the line) between frames, or back to back, produce no output bytes. A flag with no frame content since the previous flag produces nothing.
- R2: A run of seven or more consecutive ones while no frame content has been collected produces no output, whether it arrives during hunting or just after a flag.
- R3: Frame content bytes are emitted in arrival order, each assembled LSB first. The two check bytes are included and are emitted ahead of the status byte.
- R4: Inside a frame, a zero that follows five consecutive ones is discarded and contributes no data bit.
- R5: A frame that holds at least two bytes, is byte aligned, and leaves the CRC-16 residue 0xF0B8 is followed by the status byte 0x00 with `eof` high. The CRC uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), a preset of 0xFFFF, and is processed LSB first.
- R6: A byte-aligned frame of at least two bytes with any other residue is followed by the status byte 0x01 with `eof` high.
- R7: Seven consecutive ones after frame content has started end the frame. The status byte 0xFF is emitted with `eof`, and all bits up to the next flag are ignored.
- R8: A single flag both closes one frame and opens the next one.
- R9: A frame with fewer than two bytes, or whose bit count between the flags is not a multiple of 8, is followed by the status byte 0x02 with `eof` high. Its complete bytes are still emitted first.
- R10: Outputs are registered. `byte_vld` can be high only in the cycle after a cycle in which `bit_vld` was high, and `bit_in` is ignored while `bit_vld` is low. After reset, `byte_vld`, `eof` and `byte_out` are zero and the block is hunting for a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit, LSB of each byte first |
| byte_out | output | 8 | Frame byte or status byte |
| byte_vld | output | 1 | `byte_out` is to be written to the FIFO |
| eof | output | 1 | `byte_out` is the status byte of a frame |

## Verification
The hardest situation to reach from the ports is an abort that cuts a frame off mid-byte. In that case the bytes still held in the output lag window must be dropped, and only the earlier ones appear. The stimulus reaches this through a frame whose last payload bit is zero, followed by seven raw ones and then stuffed junk. The bench can then predict exactly one byte fewer than was sent. Stuffing itself is forced by payloads full of 0xFF and 0x7E. Misaligned frames get three extra bits before the closing flag. Random gaps in `bit_vld`, carrying random line values, run through the whole stream.

// File: rtl/hdlcrx_pkg.sv
package hdlcrx_pkg;

   localparam logic [7:0] ST_GOOD  = 8'h00;
   localparam logic [7:0] ST_CRC   = 8'h01;
   localparam logic [7:0] ST_LEN   = 8'h02;
   localparam logic [7:0] ST_ABORT = 8'hFF;

   // one classified line bit
   typedef struct packed {
      logic flag;   // closing zero of a flag
      logic abort;  // the run of ones reached the abort length
      logic data;   // bit is frame data
      logic dbit;   // value of the data bit
   } bit_ev_t;

endpackage

// File: rtl/hdlcrx_bitclass.sv
module hdlcrx_bitclass
   import hdlcrx_pkg::*;
#(
   parameter int STUFF_RUN = 5
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    bit_vld,
   input  logic    bit_in,
   output bit_ev_t ev
);
   localparam int FLAG_RUN  = STUFF_RUN + 1;
   localparam int ABORT_RUN = STUFF_RUN + 2;
   localparam int RW        = $clog2(ABORT_RUN + 1);

   generate
      if (STUFF_RUN < 2) begin : g_bad_run
         $error("hdlcrx_bitclass: STUFF_RUN must be at least 2");
      end
   endgenerate

   logic [RW-1:0] ones_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (bit_vld) begin
         if (!bit_in)
            ones_q <= '0;
         else if (ones_q != RW'(ABORT_RUN))
            ones_q <= ones_q + 1'b1;
      end
   end

   always_comb begin
      ev      = '0;
      ev.dbit = bit_in;
      if (bit_vld) begin
         if (bit_in) begin
            if (ones_q < RW'(STUFF_RUN))
               ev.data = 1'b1;
            else if (ones_q == RW'(FLAG_RUN))
               ev.abort = 1'b1;
         end else begin
            if (ones_q == RW'(FLAG_RUN))
               ev.flag = 1'b1;
            else if (ones_q != RW'(STUFF_RUN))
               ev.data = 1'b1;   // a zero after STUFF_RUN ones is dropped (R4)
         end
      end
   end

   p_flag_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev.flag |-> (bit_vld && !bit_in));
   p_abort_on_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev.abort |-> (bit_vld && bit_in));
   p_stuffed_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && !bit_in && $past(bit_vld && bit_in) && ev.data) |-> !ev.flag);

endmodule

// File: rtl/hdlcrx_fcs.sv
module hdlcrx_fcs #(
   parameter int               CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY  = 16'h8408,
   parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc_q
);
   generate
      if (CRC_W < 8) begin : g_bad_w
         $error("hdlcrx_fcs: CRC_W must be at least 8");
      end
   endgenerate

   logic [CRC_W-1:0] chain [0:8];
   assign chain[0] = crc_q;

   generate
      for (genvar g = 0; g < 8; g++) begin : g_stage
         assign chain[g+1] = (chain[g] >> 1) ^ ((chain[g][0] ^ din[g]) ? POLY : '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   crc_q <= INIT;
      else if (clr) crc_q <= INIT;
      else if (upd) crc_q <= chain[8];
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !upd) |=> $stable(crc_q));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlcrx_pkg::*;
#(
   parameter int               STUFF_RUN   = 5,
   parameter int               CRC_W       = 16,
   parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
   parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8,
   parameter int               MIN_BYTES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_vld,
   input  logic       bit_in,
   output logic [7:0] byte_out,
   output logic       byte_vld,
   output logic       eof
);
   // the data bits of a flag seen before it is recognised
   localparam int LAG = STUFF_RUN + 1;
   localparam int WIN = 8 + LAG;
   localparam int CW  = $clog2(WIN + 1);
   localparam int NBW = $clog2(MIN_BYTES + 1);

   generate
      if (MIN_BYTES < 1) begin : g_bad_min
         $error("hdlc_rx_deframer: MIN_BYTES must be at least 1");
      end
   endgenerate

   bit_ev_t          ev;
   logic             in_frame;
   logic [WIN-1:0]   sh, sh_nx;
   logic [CW-1:0]    cnt;
   logic [NBW-1:0]   nb;
   logic [CRC_W-1:0] crc;
   logic             full, content;
   logic [7:0]       status;

   hdlcrx_bitclass #(.STUFF_RUN(STUFF_RUN)) u_cls (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .ev(ev)
   );

   hdlcrx_fcs #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_fcs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (bit_vld && ev.flag),
      .upd   (in_frame && ev.data && full),
      .din   (sh_nx[7:0]),
      .crc_q (crc)
   );

   assign sh_nx   = {ev.dbit, sh[WIN-1:1]};
   assign full    = (cnt == CW'(WIN - 1));
   assign content = (nb != '0) || (cnt > CW'(LAG));

   always_comb begin
      if (cnt != CW'(LAG) || nb < NBW'(MIN_BYTES)) status = ST_LEN;
      else if (crc != CRC_RESIDUE)                 status = ST_CRC;
      else                                         status = ST_GOOD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         sh       <= '0;
         cnt      <= '0;
         nb       <= '0;
         byte_out <= '0;
         byte_vld <= 1'b0;
         eof      <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         eof      <= 1'b0;
         if (bit_vld) begin
            if (!in_frame) begin
               if (ev.flag) begin
                  in_frame <= 1'b1;
                  cnt      <= '0;
                  nb       <= '0;
               end
            end else if (ev.flag) begin
               if (content) begin
                  byte_out <= status;
                  byte_vld <= 1'b1;
                  eof      <= 1'b1;
               end
               cnt <= '0;   // the same flag opens the next frame
               nb  <= '0;
            end else if (ev.abort) begin
               if (content) begin
                  byte_out <= ST_ABORT;
                  byte_vld <= 1'b1;
                  eof      <= 1'b1;
               end
               in_frame <= 1'b0;
            end else if (ev.data) begin
               sh <= sh_nx;
               if (full) begin
                  byte_out <= sh_nx[7:0];
                  byte_vld <= 1'b1;
                  cnt      <= CW'(LAG);
                  if (nb != NBW'(MIN_BYTES)) nb <= nb + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   p_out_needs_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> !byte_vld);
   p_eof_has_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> byte_vld);
   p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> (byte_out == ST_GOOD || byte_out == ST_CRC ||
               byte_out == ST_LEN  || byte_out == ST_ABORT));
   p_flag_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && ev.flag && !in_frame) |=> !byte_vld);

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] byte_out;
   logic       byte_vld;
   logic       eof;

   always #10 clk = ~clk;   // 50 MHz

   hdlc_rx_deframer u_dut (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
      .byte_out(byte_out), .byte_vld(byte_vld), .eof(eof)
   );

   int errors = 0;
   int checks = 0;

   logic [7:0] exp_b [0:2047];
   logic       exp_e [0:2047];
   string      exp_t [0:2047];
   int         ei = 0;
   int         gi = 0;
   int         tx_ones = 0;
   logic [7:0] pl [0:15];
   logic       vld_at_edge = 1'b0;

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int i = 0; i < 8; i++)
         r = (r >> 1) ^ ((r[0] ^ d[i]) ? 16'h8408 : 16'h0000);
      return r;
   endfunction

   task automatic expect_b(input logic [7:0] b, input logic e, input string t);
      exp_b[ei] = b; exp_e[ei] = e; exp_t[ei] = t; ei++;
   endtask

   always @(posedge clk) vld_at_edge <= bit_vld;

   always @(negedge clk) begin
      if (rst_n && byte_vld) begin
         checks++;
         if (!vld_at_edge) begin
            errors++;
            $display("FAIL R10: byte_vld=1 expected 0 after idle input cycle");
         end else if (gi >= ei) begin
            errors++;
            $display("FAIL R1: unexpected byte=%h eof=%b, expected no output", byte_out, eof);
         end else begin
            if (byte_out !== exp_b[gi] || eof !== exp_e[gi]) begin
               errors++;
               $display("FAIL %s: got byte=%h eof=%b expected byte=%h eof=%b",
                        exp_t[gi], byte_out, eof, exp_b[gi], exp_e[gi]);
            end
            gi++;
         end
      end
   end

   task automatic tx_raw(input logic b);
      while ($urandom_range(0, 3) == 0) begin   // idle gap, line value ignored (R10)
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = b;
   endtask

   task automatic tx_data(input logic b);
      tx_raw(b);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin tx_raw(1'b0); tx_ones = 0; end   // stuffed zero (R4)
      end else tx_ones = 0;
   endtask

   task automatic tx_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) tx_data(v[i]);
   endtask

   task automatic tx_flag();
      tx_raw(1'b0);
      for (int i = 0; i < 6; i++) tx_raw(1'b1);
      tx_raw(1'b0);
      tx_ones = 0;
   endtask

   // kind: 0 good, 1 bad check, 2 misaligned, 3 abort, 4 no check bytes
   task automatic send_frame(input int n, input int kind, input string dtag);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] fcs;
      if (kind == 3) begin
         pl[n-1][7] = 1'b0;
         for (int i = 0; i < n - 1; i++) expect_b(pl[i], 1'b0, dtag);
         expect_b(8'hFF, 1'b1, "R7");
         for (int i = 0; i < n; i++) tx_byte(pl[i]);
         for (int i = 0; i < 7; i++) tx_raw(1'b1);
         tx_ones = 0;
         tx_byte(8'($urandom)); tx_byte(8'($urandom));   // ignored while hunting
         tx_flag();
         return;
      end
      if (kind == 4) begin
         for (int i = 0; i < n; i++) begin expect_b(pl[i], 1'b0, dtag); tx_byte(pl[i]); end
         if (n > 0) expect_b(8'h02, 1'b1, "R9");
         tx_flag();
         return;
      end
      for (int i = 0; i < n; i++) c = crc_upd(c, pl[i]);
      fcs = ~c;
      if (kind == 1) fcs[0] = ~fcs[0];
      for (int i = 0; i < n; i++) expect_b(pl[i], 1'b0, dtag);
      expect_b(fcs[7:0], 1'b0, "R3");
      expect_b(fcs[15:8], 1'b0, "R3");
      case (kind)
         0: expect_b(8'h00, 1'b1, "R5");
         1: expect_b(8'h01, 1'b1, "R6");
         default: expect_b(8'h02, 1'b1, "R9");
      endcase
      for (int i = 0; i < n; i++) tx_byte(pl[i]);
      tx_byte(fcs[7:0]);
      tx_byte(fcs[15:8]);
      if (kind == 2) begin tx_data(1'b0); tx_data(1'b0); tx_data(1'b0); end
      tx_flag();   // closes this frame and opens the next (R8)
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      checks++;
      if (byte_vld !== 1'b0 || eof !== 1'b0 || byte_out !== 8'h00) begin
         errors++;
         $display("FAIL R10: reset outputs vld=%b eof=%b byte=%h expected 0 0 00",
                  byte_vld, eof, byte_out);
      end
      @(negedge clk); rst_n = 1'b1;

      // R2: ones while hunting, R1: idle flags
      for (int i = 0; i < 12; i++) tx_raw(1'b1);
      tx_flag(); tx_flag(); tx_flag();
      // R2: marking idle right after a flag aborts silently
      for (int i = 0; i < 10; i++) tx_raw(1'b1);
      tx_flag();

      // R4: heavy stuffing payload
      pl[0] = 8'hFF; pl[1] = 8'hFF; pl[2] = 8'h7E; pl[3] = 8'h3E;
      send_frame(4, 0, "R4");
      // R9: single byte with no check bytes, then an empty frame (R1)
      pl[0] = 8'hA5;
      send_frame(1, 4, "R9");
      send_frame(0, 4, "R1");
      // R5: frame of only check bytes
      send_frame(0, 0, "R5");
      // R7: abort after one byte and after several
      pl[0] = 8'h5A;
      send_frame(1, 3, "R7");
      for (int i = 0; i < 5; i++) pl[i] = 8'($urandom);
      send_frame(5, 3, "R7");
      // R9: misaligned
      for (int i = 0; i < 3; i++) pl[i] = 8'($urandom);
      send_frame(3, 2, "R9");
      tx_flag();   // extra idle flag between frames (R1)

      // random mix, shared flags between frames (R8)
      for (int f = 0; f < 40; f++) begin
         int n    = $urandom_range(1, 10);
         int sel  = $urandom_range(0, 9);
         int kind = (sel < 5) ? 0 : (sel < 7) ? 1 : (sel < 8) ? 2 : 3;
         for (int i = 0; i < n; i++)
            pl[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
         send_frame(n, kind, "R3");
         if ($urandom_range(0, 4) == 0) tx_flag();
      end

      @(negedge clk); bit_vld = 1'b0;
      repeat (10) @(negedge clk);
      checks++;
      if (gi != ei) begin
         errors++;
         $display("FAIL R3: output count %0d expected %0d", gi, ei);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule